// File: doc/BRIEF.md
# Serial SAR Converter Frame Emulator

This block stands in for an eight-channel, 12-bit serial successive-approximation converter, so that a host-side serial controller can be exercised in loopback without any analog parts. The host drives an active-low chip select, a serial clock that idles high, and a data-in line carrying channel-address bits. The block oversamples all three in its own faster system clock and answers on a data-out line with 16-clock frames. Each frame holds four zero bits followed by a 12-bit straight-binary sample, most significant bit first.

The value returned for a frame comes from one of eight parallel sample inputs. It is captured at the moment the frame enters its hold phase, so the parallel source may change freely after that point. A status output separates the track phase from the hold/convert phase, and a one-cycle pulse marks the end of every completed frame. While chip select stays low, frames follow one another back to back on the same 16-clock schedule.

Top module: `sar_frame_emu`

## Requirements
- R1: Within a frame, serial clock falling edges 1 to 4 each drive `dout` to 0.
- R2: Falling edges 5 to 16 drive the 12 bits of the captured sample onto `dout`, bit 11 first and bit 0 last. The sample for channel c is `chan_samples[c*12 +: 12]`.
- R3: `din` is sampled on rising edges 3, 4 and 5 of a frame. These bits form the next channel number, most significant bit first, and that channel is used from the following frame on. The first frame after chip select falls uses channel 0.
- R4: The selected sample is captured on falling edge 4. Changes to `chan_samples` after that edge do not alter the bits sent in the same frame.
- R5: `holding` is 0 (track) from falling edge 1 until falling edge 4. It is 1 (hold/convert) from falling edge 4 through the 16th rising edge, and it stays 1 until the next frame's falling edge 1.
- R6: `frame_done` is a pulse one system clock wide. It is issued once after the 16th rising edge of each frame and never for an unfinished frame.
- R7: While chip select is high, the edge counters are cleared, `dout` is 0, `holding` is 0 and no `frame_done` is issued. An aborted frame is discarded, and the next frame uses channel 0.
- R8: After reset, `dout`, `holding` and `frame_done` are 0.
- R9: While chip select stays low, every further group of 16 serial clocks forms a complete new frame that follows R1 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, idles high, asynchronous |
| din | input | 1 | Channel-address data from the host |
| chan_samples | input | 96 | Eight 12-bit parallel sample values, channel c at bits c*12+11 down to c*12 |
| dout | output | 1 | Serial frame data to the host |
| holding | output | 1 | 0 = track phase, 1 = hold/convert phase |
| frame_done | output | 1 | One-cycle pulse after the 16th rising edge of a frame |

## Verification
The hardest condition to reach from the ports is a change to the parallel source in the middle of a frame. The change must land after the capture edge but before the bits have all shifted out, and it must hit the channel whose address was sent one frame earlier. The bench keeps its own record of the pending and active channel. In chosen frames it writes a new random value into exactly that channel's slice after falling edge 6, then expects the old value. It also raises chip select in the middle of a frame to check the discard and the return to channel 0.

// File: rtl/sfe_pkg.sv
// Package: shared frame geometry for the serial converter emulator.
// Assumes a frame length that is a power of two and a data field
// that fills the frame after the leading zero bits.
package sfe_pkg;
    localparam int SFE_CHANNELS   = 8;   // selectable parallel inputs
    localparam int SFE_RES        = 12;  // result bits per frame
    localparam int SFE_FRAME      = 16;  // serial clocks per frame
    localparam int SFE_ZEROS      = 4;   // leading zero bits; hold starts on the last
    localparam int SFE_ADDR_FIRST = 3;   // first rising edge carrying an address bit
endpackage

// File: rtl/sfe_edge_sync.sv
// Module: sfe_edge_sync
// Brings chip select, serial clock and data-in into the system clock
// domain through two flops each, then flags serial clock edges.
// Assumes the serial clock half period spans at least three system clocks.
module sfe_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_act,
    output logic din_s,
    output logic rise_p,
    output logic fall_p
);
    logic [1:0] cs_q, sclk_q, din_q;
    logic       sclk_d;

    // Two-flop synchronizers; chip select resets to deselected, clock to idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 2'b11;
            sclk_q <= 2'b11;
            din_q  <= 2'b00;
            sclk_d <= 1'b1;
        end else begin
            cs_q   <= {cs_q[0], cs_n};
            sclk_q <= {sclk_q[0], sclk};
            din_q  <= {din_q[0], din};
            sclk_d <= sclk_q[1];
        end
    end

    // Edge strobes from the synchronized clock and its delayed copy.
    always_comb begin
        cs_act = ~cs_q[1];
        din_s  = din_q[1];
        rise_p = sclk_q[1] & ~sclk_d;
        fall_p = ~sclk_q[1] & sclk_d;
    end
endmodule

// File: rtl/sfe_sequencer.sv
// Module: sfe_sequencer
// Counts serial clock edges within a frame, collects the channel address,
// drives the track/hold status and the end-of-frame pulse.
// Assumes edge strobes are one system clock wide.
module sfe_sequencer #(
    parameter int CH_N       = sfe_pkg::SFE_CHANNELS,
    parameter int FRAME      = sfe_pkg::SFE_FRAME,
    parameter int ZEROS      = sfe_pkg::SFE_ZEROS,
    parameter int ADDR_FIRST = sfe_pkg::SFE_ADDR_FIRST,
    localparam int CW        = $clog2(FRAME),
    localparam int AW        = $clog2(CH_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          din_s,
    input  logic          rise_p,
    input  logic          fall_p,
    output logic [CW:0]   fall_idx,
    output logic          hold_start,
    output logic [AW-1:0] chan_cur,
    output logic          holding,
    output logic          frame_done
);
    localparam logic [CW-1:0] LAST_CNT = CW'(FRAME - 1);
    localparam logic [CW:0]   IDX_ONE  = (CW+1)'(1);
    localparam logic [CW:0]   IDX_HOLD = (CW+1)'(ZEROS);
    localparam logic [CW:0]   IDX_A0   = (CW+1)'(ADDR_FIRST);
    localparam logic [CW:0]   IDX_AN   = (CW+1)'(ADDR_FIRST + AW);
    localparam logic [CW:0]   IDX_END  = (CW+1)'(FRAME);

    logic [CW-1:0] fall_n, rise_n;
    logic [CW:0]   rise_idx;
    logic [AW-1:0] addr_sh;

    // One-based index of the edge being seen now.
    always_comb begin
        fall_idx   = {1'b0, fall_n} + IDX_ONE;
        rise_idx   = {1'b0, rise_n} + IDX_ONE;
        hold_start = fall_p && (fall_idx == IDX_HOLD);
    end

    // Edge counters, address shift, phase status and end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            fall_n     <= '0;
            rise_n     <= '0;
            addr_sh    <= '0;
            chan_cur   <= '0;
            holding    <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (fall_p) begin
                fall_n <= (fall_n == LAST_CNT) ? '0 : fall_n + 1'b1;
                if (fall_idx == IDX_ONE)
                    holding <= 1'b0;
                else if (fall_idx == IDX_HOLD)
                    holding <= 1'b1;
            end
            if (rise_p) begin
                rise_n <= (rise_n == LAST_CNT) ? '0 : rise_n + 1'b1;
                if (rise_idx >= IDX_A0 && rise_idx < IDX_AN)
                    addr_sh <= {addr_sh[AW-2:0], din_s};
                if (rise_idx == IDX_END) begin
                    frame_done <= 1'b1;
                    chan_cur   <= addr_sh;
                end
            end
        end
    end

    // R6: the end-of-frame pulse lasts one cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R5: a frame only finishes while in hold.
    assert_done_in_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> holding);
endmodule

// File: rtl/sfe_shifter.sv
// Module: sfe_shifter
// Captures the selected channel's sample at hold start and shifts it out,
// leading zeros first, on each serial clock falling edge.
// Assumes fall_idx runs from 1 to FRAME and FRAME - ZEROS equals RES.
module sfe_shifter #(
    parameter int CH_N   = sfe_pkg::SFE_CHANNELS,
    parameter int RES    = sfe_pkg::SFE_RES,
    parameter int FRAME  = sfe_pkg::SFE_FRAME,
    parameter int ZEROS  = sfe_pkg::SFE_ZEROS,
    localparam int CW    = $clog2(FRAME),
    localparam int AW    = $clog2(CH_N),
    localparam int RW    = $clog2(RES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              fall_p,
    input  logic              hold_start,
    input  logic              holding,
    input  logic [CW:0]       fall_idx,
    input  logic [AW-1:0]     chan_cur,
    input  logic [CH_N*RES-1:0] chan_samples,
    output logic              dout
);
    localparam logic [CW:0] IDX_ZEND = (CW+1)'(ZEROS);

    logic [RES-1:0] held;
    logic [RES-1:0] pick;
    logic [RW-1:0]  bsel;

    // Channel mux and the bit position for the current falling edge.
    always_comb begin
        pick = chan_samples[int'(chan_cur)*RES +: RES];
        bsel = RW'(FRAME - int'(fall_idx));
    end

    // Sample capture and serial output register.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            held <= '0;
            dout <= 1'b0;
        end else if (hold_start) begin
            held <= pick;
            dout <= 1'b0;
        end else if (fall_p) begin
            dout <= (fall_idx <= IDX_ZEND) ? 1'b0 : held[bsel];
        end
    end

    // R4: the captured sample does not move during hold.
    assert_held_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && $past(holding)) |-> $stable(held));
endmodule

// File: rtl/sar_frame_emu.sv
// Module: sar_frame_emu
// Device-side model of an eight-channel serial SAR converter answering
// 16-clock frames. Assumes the system clock oversamples the serial clock
// by at least six.
module sar_frame_emu #(
    parameter int CH_N       = sfe_pkg::SFE_CHANNELS,
    parameter int RES        = sfe_pkg::SFE_RES,
    parameter int FRAME      = sfe_pkg::SFE_FRAME,
    parameter int ZEROS      = sfe_pkg::SFE_ZEROS,
    parameter int ADDR_FIRST = sfe_pkg::SFE_ADDR_FIRST
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                din,
    input  logic [CH_N*RES-1:0] chan_samples,
    output logic                dout,
    output logic                holding,
    output logic                frame_done
);
    localparam int CW = $clog2(FRAME);
    localparam int AW = $clog2(CH_N);

    logic          cs_act, din_s, rise_p, fall_p, hold_start;
    logic [CW:0]   fall_idx;
    logic [AW-1:0] chan_cur;

    sfe_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .din    (din),
        .cs_act (cs_act),
        .din_s  (din_s),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    sfe_sequencer #(
        .CH_N(CH_N), .FRAME(FRAME), .ZEROS(ZEROS), .ADDR_FIRST(ADDR_FIRST)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .din_s      (din_s),
        .rise_p     (rise_p),
        .fall_p     (fall_p),
        .fall_idx   (fall_idx),
        .hold_start (hold_start),
        .chan_cur   (chan_cur),
        .holding    (holding),
        .frame_done (frame_done)
    );

    sfe_shifter #(
        .CH_N(CH_N), .RES(RES), .FRAME(FRAME), .ZEROS(ZEROS)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_act       (cs_act),
        .fall_p       (fall_p),
        .hold_start   (hold_start),
        .holding      (holding),
        .fall_idx     (fall_idx),
        .chan_cur     (chan_cur),
        .chan_samples (chan_samples),
        .dout         (dout)
    );

    // R1: entering hold happens on a leading-zero bit.
    assert_hold_entry_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(holding) |-> (dout == 1'b0));

    // R7: a deselected device goes idle on the next cycle.
    assert_deselect_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!holding && !dout && !frame_done));
endmodule

// File: tb/sim_sar_frame_emu.sv
module sim_sar_frame_emu;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;     // system clocks per serial half period
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic [95:0] chan_samples = '0;
    logic        dout, holding, frame_done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cycles = 0;
    logic [2:0] exp_chan;   // channel the current frame converts

    sar_frame_emu u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .chan_samples(chan_samples), .dout(dout), .holding(holding),
        .frame_done(frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (frame_done) done_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] slice_of(input logic [95:0] s, input logic [2:0] c);
        return s[int'(c)*12 +: 12];
    endfunction

    function automatic logic [15:0] expect_frame(input logic [11:0] v);
        return {4'b0000, v};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full frame: sends next_ch, optionally disturbs the source after edge 6.
    task automatic run_frame(input logic [2:0] next_ch, input bit disturb);
        logic [15:0] rx;
        logic [11:0] want;
        int start_done;
        bit hold_ok;
        want = slice_of(chan_samples, exp_chan);
        start_done = done_cnt;
        hold_ok = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            sclk = 1'b0;
            if (k >= 3 && k <= 5) din = next_ch[5-k];
            wait_clk(HALF);
            rx[16-k] = dout;
            if (holding !== (k >= 4)) hold_ok = 1'b0;
            if (disturb && k == 6)
                chan_samples[int'(exp_chan)*12 +: 12] = 12'($urandom);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        chk("R1 leading zeros", 32'(rx[15:12]), 32'h0);
        chk(disturb ? "R4 R2 data held" : "R2 data", 32'(rx), 32'(expect_frame(want)));
        chk("R5 track/hold schedule", 32'(hold_ok), 32'h1);
        chk("R5 hold after frame", 32'(holding), 32'h1);
        chk("R6 one done per frame", 32'(done_cnt - start_done), 32'h1);
        exp_chan = next_ch;
    endtask

    task automatic select_low;
        cs_n = 1'b0;
        exp_chan = 3'd0;
        wait_clk(HALF);
    endtask

    task automatic deselect;
        cs_n = 1'b1;
        sclk = 1'b1;
        wait_clk(6);
        chk("R7 dout idle", 32'(dout), 32'h0);
        chk("R7 track when idle", 32'(holding), 32'h0);
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int c = 0; c < 8; c++) chan_samples[c*12 +: 12] = 12'($urandom);
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R8 reset dout", 32'(dout), 32'h0);
        chk("R8 reset holding", 32'(holding), 32'h0);
        chk("R8 reset frame_done", 32'(frame_done), 32'h0);

        // R3 R9: back-to-back random frames; first frame converts channel 0.
        select_low();
        for (int f = 0; f < 8; f++)
            run_frame(3'($urandom), (f % 3) == 2);
        deselect();

        // Directed extremes on channel 7 and channel 0.
        chan_samples[7*12 +: 12] = 12'hFFF;
        chan_samples[0 +: 12]    = 12'h000;
        select_low();
        run_frame(3'd7, 1'b0);           // R3 channel 0 first
        run_frame(3'd0, 1'b1);           // R4 all-ones held against a disturbance
        run_frame(3'd5, 1'b0);
        deselect();

        // R7: abort mid-frame after edge 7, then restart at channel 0.
        select_low();
        run_frame(3'd6, 1'b0);
        begin
            int d0;
            d0 = done_cnt;
            for (int k = 1; k <= 7; k++) begin
                sclk = 1'b0; wait_clk(HALF);
                sclk = 1'b1; wait_clk(HALF);
            end
            deselect();
            chk("R7 no done on abort", 32'(done_cnt - d0), 32'h0);
        end
        select_low();
        run_frame(3'd2, 1'b0);           // R7 R3 channel 0 after abort
        run_frame(3'd1, 1'b1);
        deselect();

        // Random bursts with fresh sample contents.
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 8; c++) chan_samples[c*12 +: 12] = 12'($urandom);
            select_low();
            for (int f = 0; f < 5; f++) run_frame(3'($urandom), 1'($urandom));
            deselect();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule